// File: doc/BRIEF.md
# Disk Drive Tag Command Decoder

This block sits on the drive side of a daisy-chained disk control cable. The controller uses four strobes that share one bus. A unit-select strobe latches a 4-bit unit number. Three numbered tags then load a 10-bit bus as a cylinder address, a head address or a control word. The block compares the latched unit number with its own configured address. Only while the two match does it act on the numbered tags and drive its status lines back to the controller.

All cable inputs pass through two-flop synchronizers, and each strobe is detected on its rising edge in the system clock domain. The control word holds two gates, write and read, which are ANDed with the serial write and read clocks. It also holds two request bits, return-to-zero and fault clear. A rising edge on either request bit produces a one-cycle event pulse.

A seek to a cylinder below the configured limit loads the cylinder and drops on-cylinder for a fixed settle time. A seek to a cylinder at or above the limit raises seek error instead. When the cable is reported disconnected, every status line is held inactive.

Top module: `disk_tag_decoder`

## Requirements
- R1: After reset, unit_sel_o, seek_err_o, fault_o, ready_o, wr_prot_o, rtz_pulse_o, fclr_pulse_o, wr_clk_en_o and rd_clk_en_o are 0, and cyl_o and head_o are 0.
- R2: A rising unit-select strobe latches sel_bits_i. unit_sel_o and ready_o are 1 only while the latched value equals unit_addr_i. wr_prot_o follows wr_prot_i only while the unit is selected.
- R3: A rising tag1_i with bus_i below MAX_CYL loads bus_i into cyl_o and clears seek_err_o.
- R4: A rising tag1_i with bus_i at or above MAX_CYL sets seek_err_o and leaves cyl_o unchanged.
- R5: After a valid seek, on_cyl_o goes to 0 for SEEK_CYCLES cycles and then returns to 1. on_cyl_o is 1 after reset while the unit is selected.
- R6: A rising tag2_i loads bus_i into head_o.
- R7: A rising tag3_i latches a control word from bus_i. Bit 0 is write gate, bit 1 is read gate, bit 4 is fault clear and bit 6 is return-to-zero; all other bits are ignored. wr_clk_en_o equals write_clk_i AND write gate, and rd_clk_en_o equals read_clk_i AND read gate.
- R8: A 0-to-1 change of the latched return-to-zero bit gives a single one-cycle rtz_pulse_o, sets cyl_o to 0 and clears seek_err_o.
- R9: fault_i high sets a sticky fault flag shown on fault_o. A 0-to-1 change of the latched fault-clear bit gives a single one-cycle fclr_pulse_o and clears the flag, unless fault_i is high in the same cycle, in which case the flag stays set.
- R10: While the unit is not selected, tag1_i, tag2_i and tag3_i are ignored.
- R11: While cable_open_i is 1, unit_sel_o, on_cyl_o, seek_err_o, fault_o, ready_o and wr_prot_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unit_addr_i | input | 4 | Configured unit number of this drive |
| sel_tag_i | input | 1 | Unit-select strobe |
| sel_bits_i | input | 4 | Unit-select field |
| tag1_i | input | 1 | Cylinder strobe |
| tag2_i | input | 1 | Head strobe |
| tag3_i | input | 1 | Control-word strobe |
| bus_i | input | 10 | Shared command bus |
| cable_open_i | input | 1 | High when the control cable is disconnected |
| fault_i | input | 1 | Fault condition from the drive side |
| wr_prot_i | input | 1 | Write-protect setting |
| write_clk_i | input | 1 | Serial write clock from the controller |
| read_clk_i | input | 1 | Serial read clock |
| unit_sel_o | output | 1 | Unit selected |
| on_cyl_o | output | 1 | Heads settled on cylinder |
| seek_err_o | output | 1 | Seek to an illegal cylinder |
| fault_o | output | 1 | Sticky fault flag |
| ready_o | output | 1 | Unit ready |
| wr_prot_o | output | 1 | Write protected |
| cyl_o | output | 10 | Current cylinder |
| head_o | output | 10 | Current head |
| rtz_pulse_o | output | 1 | Return-to-zero event pulse |
| fclr_pulse_o | output | 1 | Fault-clear event pulse |
| wr_clk_en_o | output | 1 | Gated write clock |
| rd_clk_en_o | output | 1 | Gated read clock |

## Verification
Two events can act on the fault flag in the same cycle: a new fault and a fault-clear pulse. The bench holds fault_i high while it strobes a control word whose fault-clear bit is set. It then checks that fault_o is still 1 and that fclr_pulse_o fired exactly once. Next it drops fault_i, strobes a control word with the clear bit at 0 and then one with the clear bit at 1, and expects fault_o to fall. This shows that the clear works by itself and that only the overlap is resolved in favour of the set.

// File: rtl/disk_tag_pkg.sv
package disk_tag_pkg;
  localparam int unsigned UNIT_W = 4;
  localparam int unsigned BUS_W  = 10;

  // control word bit positions on the bus
  localparam int unsigned CW_WR_GATE = 0;
  localparam int unsigned CW_RD_GATE = 1;
  localparam int unsigned CW_FCLR    = 4;
  localparam int unsigned CW_RTZ     = 6;

  typedef struct packed {
    logic rtz;
    logic fclr;
    logic rd_gate;
    logic wr_gate;
  } ctrl_word_t;
endpackage

// File: rtl/tag_sync.sv
module tag_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tag_capture.sv
module tag_capture
  import disk_tag_pkg::*;
#(
  parameter int unsigned U_W = UNIT_W,
  parameter int unsigned B_W = BUS_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [U_W-1:0] unit_addr_i,
  input  logic           sel_tag_i,
  input  logic [U_W-1:0] sel_bits_i,
  input  logic [2:0]     tag_i,
  input  logic [B_W-1:0] bus_i,
  output logic           match_o,
  output logic           seek_go_o,
  output logic [B_W-1:0] head_o,
  output ctrl_word_t     ctrl_o,
  output logic           rtz_pulse_o,
  output logic           fclr_pulse_o
);
  logic [3:0]     strobe_prev_q;
  logic [3:0]     strobe_rise;
  logic [U_W-1:0] unit_q;
  logic           unit_valid_q;
  logic [B_W-1:0] head_q;
  ctrl_word_t     ctrl_q;
  logic           rtz_prev_q, fclr_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_prev_q <= '0;
    else         strobe_prev_q <= {tag_i, sel_tag_i};
  end

  assign strobe_rise = {tag_i, sel_tag_i} & ~strobe_prev_q;
  assign match_o     = unit_valid_q && (unit_q == unit_addr_i);
  assign seek_go_o   = strobe_rise[1] && match_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q       <= '0;
      unit_valid_q <= 1'b0;
    end else if (strobe_rise[0]) begin
      unit_q       <= sel_bits_i;
      unit_valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        head_q <= '0;
    else if (strobe_rise[2] && match_o) head_q <= bus_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (strobe_rise[3] && match_o) begin
      ctrl_q.wr_gate <= bus_i[CW_WR_GATE];
      ctrl_q.rd_gate <= bus_i[CW_RD_GATE];
      ctrl_q.fclr    <= bus_i[CW_FCLR];
      ctrl_q.rtz     <= bus_i[CW_RTZ];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtz_prev_q  <= 1'b0;
      fclr_prev_q <= 1'b0;
    end else begin
      rtz_prev_q  <= ctrl_q.rtz;
      fclr_prev_q <= ctrl_q.fclr;
    end
  end

  assign rtz_pulse_o  = ctrl_q.rtz  & ~rtz_prev_q;
  assign fclr_pulse_o = ctrl_q.fclr & ~fclr_prev_q;
  assign head_o       = head_q;
  assign ctrl_o       = ctrl_q;

  // R10
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_o && strobe_rise[2]) |=> $stable(head_q));
  // R8
  rtz_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtz_pulse_o |=> !rtz_pulse_o);
  // R9
  fclr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fclr_pulse_o |=> !fclr_pulse_o);
endmodule

// File: rtl/seek_ctrl.sv
module seek_ctrl #(
  parameter int unsigned B_W         = 10,
  parameter int unsigned MAX_CYL     = 823,
  parameter int unsigned SEEK_CYCLES = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           seek_go_i,
  input  logic [B_W-1:0] target_i,
  input  logic           rtz_i,
  output logic [B_W-1:0] cyl_o,
  output logic           seek_err_o,
  output logic           on_cyl_o
);
  localparam int unsigned TW = $clog2(SEEK_CYCLES + 1);
  localparam logic [TW-1:0] SETTLE = TW'(SEEK_CYCLES);

  logic [B_W-1:0] cyl_q;
  logic           err_q;
  logic [TW-1:0]  settle_q;
  logic           illegal;

  assign illegal = ({22'd0, target_i} >= 32'(MAX_CYL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_q    <= '0;
      err_q    <= 1'b0;
      settle_q <= '0;
    end else begin
      if (settle_q != '0) settle_q <= settle_q - 1'b1;
      if (rtz_i) begin
        cyl_q <= '0;
        err_q <= 1'b0;
      end else if (seek_go_i) begin
        if (illegal) begin
          err_q <= 1'b1;
        end else begin
          cyl_q    <= target_i;
          err_q    <= 1'b0;
          settle_q <= SETTLE;
        end
      end
    end
  end

  assign cyl_o      = cyl_q;
  assign seek_err_o = err_q;
  assign on_cyl_o   = (settle_q == '0);

  // R4
  bad_seek_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_go_i && illegal && !rtz_i) |=> (err_q && $stable(cyl_q)));
  // R5
  settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_go_i && !illegal && !rtz_i) |=> !on_cyl_o);
  // R8
  rtz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtz_i |=> (cyl_q == '0 && !err_q));
endmodule

// File: rtl/disk_tag_decoder.sv
module disk_tag_decoder
  import disk_tag_pkg::*;
#(
  parameter int unsigned MAX_CYL     = 823,
  parameter int unsigned SEEK_CYCLES = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [UNIT_W-1:0] unit_addr_i,
  input  logic              sel_tag_i,
  input  logic [UNIT_W-1:0] sel_bits_i,
  input  logic              tag1_i,
  input  logic              tag2_i,
  input  logic              tag3_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              cable_open_i,
  input  logic              fault_i,
  input  logic              wr_prot_i,
  input  logic              write_clk_i,
  input  logic              read_clk_i,
  output logic              unit_sel_o,
  output logic              on_cyl_o,
  output logic              seek_err_o,
  output logic              fault_o,
  output logic              ready_o,
  output logic              wr_prot_o,
  output logic [BUS_W-1:0]  cyl_o,
  output logic [BUS_W-1:0]  head_o,
  output logic              rtz_pulse_o,
  output logic              fclr_pulse_o,
  output logic              wr_clk_en_o,
  output logic              rd_clk_en_o
);
  localparam int unsigned SYNC_W = 1 + UNIT_W + 3 + BUS_W + 1;

  logic [SYNC_W-1:0] raw, synced;
  logic              sel_tag_s, open_s;
  logic [UNIT_W-1:0] sel_bits_s;
  logic [2:0]        tag_s;
  logic [BUS_W-1:0]  bus_s;

  assign raw = {cable_open_i, bus_i, tag3_i, tag2_i, tag1_i, sel_bits_i, sel_tag_i};
  assign {open_s, bus_s, tag_s, sel_bits_s, sel_tag_s} = synced;

  tag_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  logic       match, seek_go, rtz_pulse, fclr_pulse;
  ctrl_word_t ctrl;
  logic       seek_err, on_cyl;

  tag_capture #(.U_W(UNIT_W), .B_W(BUS_W)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .unit_addr_i (unit_addr_i),
    .sel_tag_i   (sel_tag_s),
    .sel_bits_i  (sel_bits_s),
    .tag_i       (tag_s),
    .bus_i       (bus_s),
    .match_o     (match),
    .seek_go_o   (seek_go),
    .head_o      (head_o),
    .ctrl_o      (ctrl),
    .rtz_pulse_o (rtz_pulse),
    .fclr_pulse_o(fclr_pulse)
  );

  seek_ctrl #(.B_W(BUS_W), .MAX_CYL(MAX_CYL), .SEEK_CYCLES(SEEK_CYCLES)) u_seek (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seek_go_i (seek_go),
    .target_i  (bus_s),
    .rtz_i     (rtz_pulse),
    .cyl_o     (cyl_o),
    .seek_err_o(seek_err),
    .on_cyl_o  (on_cyl)
  );

  logic fault_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fault_q <= 1'b0;
    else if (fault_i)    fault_q <= 1'b1;   // set beats clear
    else if (fclr_pulse) fault_q <= 1'b0;
  end

  logic drive_ok;
  assign drive_ok = match && !open_s;

  assign unit_sel_o   = drive_ok;
  assign ready_o      = drive_ok;
  assign on_cyl_o     = drive_ok && on_cyl;
  assign seek_err_o   = drive_ok && seek_err;
  assign fault_o      = drive_ok && fault_q;
  assign wr_prot_o    = drive_ok && wr_prot_i;
  assign rtz_pulse_o  = rtz_pulse;
  assign fclr_pulse_o = fclr_pulse;
  assign wr_clk_en_o  = write_clk_i & ctrl.wr_gate;
  assign rd_clk_en_o  = read_clk_i & ctrl.rd_gate;

  // R9
  fault_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> fault_q);
  // R9
  fault_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fclr_pulse && !fault_i) |=> !fault_q);
endmodule

// File: tb/disk_tag_decoder_tb.sv
module disk_tag_decoder_tb;
  localparam int unsigned MAX_CYL = 100;
  localparam int unsigned SEEK_CY = 12;
  localparam logic [3:0]  MY_UNIT = 4'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel_bits = '0;
  logic       sel_tag = 0, tag1 = 0, tag2 = 0, tag3 = 0;
  logic [9:0] bus = '0;
  logic       cable_open = 0, fault_in = 0, wp = 0, wclk = 0, rclk = 0;
  logic       unit_sel, on_cyl, seek_err, fault, ready, wr_prot;
  logic [9:0] cyl, head;
  logic       rtz_p, fclr_p, wr_en, rd_en;

  int errors = 0, checks = 0;
  int rtz_cnt = 0, fclr_cnt = 0;

  always #2 clk = ~clk;

  disk_tag_decoder #(.MAX_CYL(MAX_CYL), .SEEK_CYCLES(SEEK_CY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .unit_addr_i(MY_UNIT),
    .sel_tag_i(sel_tag), .sel_bits_i(sel_bits),
    .tag1_i(tag1), .tag2_i(tag2), .tag3_i(tag3), .bus_i(bus),
    .cable_open_i(cable_open), .fault_i(fault_in), .wr_prot_i(wp),
    .write_clk_i(wclk), .read_clk_i(rclk),
    .unit_sel_o(unit_sel), .on_cyl_o(on_cyl), .seek_err_o(seek_err),
    .fault_o(fault), .ready_o(ready), .wr_prot_o(wr_prot),
    .cyl_o(cyl), .head_o(head), .rtz_pulse_o(rtz_p), .fclr_pulse_o(fclr_p),
    .wr_clk_en_o(wr_en), .rd_clk_en_o(rd_en)
  );

  always @(negedge clk) begin
    if (rtz_p)  rtz_cnt++;
    if (fclr_p) fclr_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0=select 1=tag1 2=tag2 3=tag3
  task automatic strobe(input int which, input logic [9:0] val);
    @(negedge clk);
    if (which == 0) sel_bits = val[3:0]; else bus = val;
    cycles(3);
    case (which)
      0: sel_tag = 1;
      1: tag1 = 1;
      2: tag2 = 1;
      default: tag3 = 1;
    endcase
    cycles(4);
    {sel_tag, tag1, tag2, tag3} = '0;
    cycles(4);
  endtask

  // seek vectors: command, expected cylinder, expected seek error
  localparam int NV = 6;
  localparam logic [9:0] V_CMD [NV] = '{10'd40, 10'd99, 10'd100, 10'd0, 10'd250, 10'd7};
  localparam logic [9:0] V_CYL [NV] = '{10'd40, 10'd99, 10'd99,  10'd0, 10'd0,   10'd7};
  localparam logic       V_ERR [NV] = '{1'b0,   1'b0,   1'b1,    1'b0,  1'b1,    1'b0};

  initial begin
    fork
      begin
        cycles(3);
        // R1 reset state
        chk("R1 unit_sel", unit_sel, 0);
        chk("R1 cyl", cyl, 0);
        chk("R1 head", head, 0);
        chk("R1 fault", fault, 0);
        chk("R1 pulses", rtz_p | fclr_p, 0);
        chk("R1 clk en", wr_en | rd_en, 0);
        rst_n = 1;
        cycles(3);

        // R2 select another unit, then ours
        wp = 1;
        strobe(0, 10'd5);
        chk("R2 other unit", unit_sel, 0);
        chk("R2 ready other", ready, 0);
        strobe(0, {6'd0, MY_UNIT});
        chk("R2 own unit", unit_sel, 1);
        chk("R2 ready", ready, 1);
        chk("R2 wr_prot", wr_prot, 1);
        chk("R5 on_cyl idle", on_cyl, 1);

        // R3 R4 R5 vector walk
        for (int i = 0; i < NV; i++) begin
          strobe(1, V_CMD[i]);
          if (!V_ERR[i]) chk("R5 on_cyl settling", on_cyl, 0);
          cycles(SEEK_CY + 4);
          chk(V_ERR[i] ? "R4 cyl held" : "R3 cyl", cyl, V_CYL[i]);
          chk(V_ERR[i] ? "R4 seek_err" : "R3 seek_err", seek_err, V_ERR[i]);
          chk("R5 on_cyl back", on_cyl, 1);
        end

        // R6 head load
        strobe(2, 10'd517);
        chk("R6 head", head, 517);

        // R7 gates, bits 0 and 1 only; other bits ignored
        wclk = 1; rclk = 1;
        strobe(3, 10'b10_1010_1101);  // bit0=1 bit1=0 bit4=0 bit6=0
        chk("R7 wr_en", wr_en, 1);
        chk("R7 rd_en", rd_en, 0);
        chk("R7 no rtz", rtz_cnt, 0);
        chk("R7 no fclr", fclr_cnt, 0);
        wclk = 0; #1;
        chk("R7 wr_en follows clk", wr_en, 0);
        strobe(3, 10'b00_0000_0010);
        chk("R7 rd_en", rd_en, 1);
        chk("R7 wr gate off", wr_en, 0);
        rclk = 0; wclk = 1;

        // R8 return-to-zero after a bad seek
        strobe(1, 10'd55);
        strobe(1, 10'd300);
        chk("R8 pre err", seek_err, 1);
        rtz_cnt = 0;
        strobe(3, 10'b00_0100_0000);
        chk("R8 rtz pulse count", rtz_cnt, 1);
        chk("R8 cyl zero", cyl, 0);
        chk("R8 err clear", seek_err, 0);

        // R9 fault set wins over a coinciding clear
        fault_in = 1;
        cycles(2);
        chk("R9 fault set", fault, 1);
        fclr_cnt = 0;
        strobe(3, 10'b00_0001_0000);
        chk("R9 fclr pulse count", fclr_cnt, 1);
        chk("R9 set wins", fault, 1);
        fault_in = 0;
        strobe(3, 10'd0);
        strobe(3, 10'b00_0001_0000);
        chk("R9 fclr second", fclr_cnt, 2);
        chk("R9 fault cleared", fault, 0);

        // R10 tags ignored while not selected
        strobe(0, 10'd9);
        strobe(1, 10'd33);
        strobe(2, 10'd44);
        strobe(3, 10'b00_0000_0011);
        strobe(0, {6'd0, MY_UNIT});
        chk("R10 cyl kept", cyl, 0);
        chk("R10 head kept", head, 517);
        rclk = 1;
        #1;
        chk("R10 gates kept", {wr_en, rd_en}, 0);
        chk("R10 on_cyl", on_cyl, 1);

        // R11 open cable forces status inactive
        fault_in = 1;
        strobe(1, 10'd400);
        cycles(2);
        chk("R11 pre fault", fault, 1);
        cable_open = 1;
        cycles(4);
        chk("R11 status", {unit_sel, on_cyl, seek_err, fault, ready, wr_prot}, 0);
        cable_open = 0;
        cycles(4);
        chk("R11 restored", {unit_sel, seek_err, fault}, 3'b111);
      end
      begin
        cycles(100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule